// File: doc/BRIEF.md
# Three-Phase Half-Bridge Protection Sequencer

This block is the digital control and protection sequencer for three independent half-bridge output stages. For every channel it takes a drive level and an enable, and from them it produces a high-side and a low-side gate command. It also drives a charge-pump enable, a regulator enable and an active-low fault flag. Analog detectors raise the supply-undervoltage, over-temperature and per-channel overcurrent flags, and these arrive as digital levels.

Fault handling follows three recovery policies:
- Undervoltage and over-temperature suspend all drive for as long as they last, and normal drive returns by itself when they clear.
- A qualified overcurrent turns off only the channel that raised it. That channel stays latched off until the fault-clear input is pulsed low or the supply drops into undervoltage.
- A sleep request wipes all internal state. After sleep ends, a wake delay must run out before any channel drives again.

Every input is resynchronized through two flops, and every output is registered.

Top module: `hb3_guard`

## Requirements
- R1: With all protections idle, the outputs of a channel follow its inputs. Enable low gives both gates off. Enable high with level 0 gives the low-side gate on. Enable high with level 1 gives the high-side gate on.
- R2: While undervoltage is seen:
  - all gates are off;
  - the pump enable is low and the fault flag is low;
  - latched overcurrents are cleared.
  After the flag drops, drive, pump and a released fault flag return with no other action.
- R3: While over-temperature is seen, all gates are off and the fault flag is low, but the pump enable stays high. Drive and a released flag return by themselves after the flag drops.
- R4: An overcurrent flag has no effect unless it stays high for OCP_CYC consecutive synchronized cycles. A shorter pulse leaves drive and the fault flag untouched, and the count starts again on the next pulse.
- R5: A qualified overcurrent turns off both gates of that channel only and pulls the fault flag low. Both stay that way after the overcurrent flag drops, until a clear, an undervoltage or a sleep.
- R6: While the fault-clear input is low:
  - all gates are off;
  - level and enable are ignored;
  - latched overcurrents are removed, so the fault flag goes high when no other fault is present.
- R7: While sleep is requested, the gates, the pump enable and the regulator enable are all low. After sleep is released, the gates stay off until WAKE_CYC synchronized cycles have passed. In cycle counts, with the release applied just before edge 1, the outputs are still off after edge WAKE_CYC+2 and drive after edge WAKE_CYC+3.
- R8: The high-side and low-side gates of a channel are never on together. A change of drive direction puts one cycle with both gates off before the new side turns on.
- R9: A change on an input reaches the outputs on the third rising edge after it is applied, because of two synchronizer flops plus the output register.
- R10: While the power-on reset is high, and on leaving it, the outputs are as follows:
  - all gates are off;
  - the pump and regulator enables are low;
  - the fault flag is high;
  - no overcurrent is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| drv_level | input | NCH | Requested output level per channel |
| drv_en | input | NCH | Output enable per channel |
| sleep_n | input | 1 | Sleep request, active low |
| clear_n | input | 1 | Fault clear, active low |
| uv_flag | input | 1 | Supply undervoltage detected |
| ot_flag | input | 1 | Over-temperature detected |
| oc_flag | input | NCH | Raw overcurrent detected per channel |
| gate_hi | output | NCH | High-side gate command per channel |
| gate_lo | output | NCH | Low-side gate command per channel |
| pump_en | output | 1 | Charge-pump enable |
| reg_en | output | 1 | Regulator enable |
| fault_n | output | 1 | Fault flag, active low |

## Verification
Internal errors show up at the ports within a few cycles:
- A wrong overcurrent counter shows as a latch that sets one edge early or late, or as a short pulse that kills a channel. Either one appears three edges later, on that channel's gates and on the fault flag.
- A latch that is not cleared shows as a channel still dark after a clear, undervoltage or sleep.
- A wake counter that is off by one moves the first driving edge by exactly one cycle.
- Lost dead time shows as a direct jump from one gate side to the other in a single cycle.

A cycle-accurate reference model in the bench catches all of these at the cycle where the outputs first diverge.

// File: rtl/hb3_guard.sv
module hb3_guard #(
  parameter int NCH      = 3,
  parameter int OCP_CYC  = 300,
  parameter int WAKE_CYC = 100000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] drv_level,
  input  logic [NCH-1:0] drv_en,
  input  logic           sleep_n,
  input  logic           clear_n,
  input  logic           uv_flag,
  input  logic           ot_flag,
  input  logic [NCH-1:0] oc_flag,
  output logic [NCH-1:0] gate_hi,
  output logic [NCH-1:0] gate_lo,
  output logic           pump_en,
  output logic           reg_en,
  output logic           fault_n
);
  localparam int W   = 3*NCH + 4;
  localparam int OCW = $clog2(OCP_CYC + 1);
  localparam int WKW = $clog2(WAKE_CYC + 1);
  localparam logic [W-1:0] SAFE = {{(W-4){1'b0}}, 4'b1100};

  logic [W-1:0] sync1, sync2;
  wire  [W-1:0] raw = {drv_level, drv_en, oc_flag, sleep_n, clear_n, uv_flag, ot_flag};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= SAFE;
      sync2 <= SAFE;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
    end
  end

  logic [NCH-1:0] lvl_a, en_a, oc_a, oc_latch;
  logic sleep_a, clr_a, uv_a, ot_a, wipe, hold;
  logic [WKW-1:0] wake_cnt;

  assign lvl_a   = sync2[3*NCH+3 : 2*NCH+4];
  assign en_a    = sync2[2*NCH+3 : NCH+4];
  assign oc_a    = sync2[NCH+3 : 4];
  assign sleep_a = ~sync2[3];
  assign clr_a   = ~sync2[2];
  assign uv_a    = sync2[1];
  assign ot_a    = sync2[0];
  assign wipe    = sleep_a | uv_a | clr_a;
  assign hold    = wake_cnt != '0;

  always_ff @(posedge clk) begin
    if (rst)          wake_cnt <= '0;
    else if (sleep_a) wake_cnt <= WKW'(WAKE_CYC);
    else if (hold)    wake_cnt <= wake_cnt - 1'b1;
  end

  wire run = ~sleep_a & ~uv_a & ~clr_a & ~ot_a & ~hold;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [OCW-1:0] cnt;
    logic lat, hi_q, lo_q;
    wire ok = run & ~lat & en_a[i];

    always_ff @(posedge clk) begin
      if (rst || wipe) begin
        cnt <= '0;
        lat <= 1'b0;
      end else if (!oc_a[i]) begin
        cnt <= '0;
      end else if (!lat) begin
        if (cnt == OCW'(OCP_CYC - 1)) lat <= 1'b1;
        else                           cnt <= cnt + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else begin
        hi_q <= ok &  lvl_a[i] & ~lo_q;
        lo_q <= ok & ~lvl_a[i] & ~hi_q;
      end
    end

    assign oc_latch[i] = lat;
    assign gate_hi[i]  = hi_q;
    assign gate_lo[i]  = lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_en <= 1'b0;
      reg_en  <= 1'b0;
      fault_n <= 1'b1;
    end else begin
      pump_en <= ~sleep_a & ~uv_a;
      reg_en  <= ~sleep_a;
      fault_n <= ~(uv_a | ot_a | (|oc_latch));
    end
  end
endmodule

// File: rtl/hb3_guard_chk.sv
module hb3_guard_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] gate_hi,
  input logic [NCH-1:0] gate_lo,
  input logic           pump_en,
  input logic           reg_en,
  input logic           fault_n,
  input logic           sleep_a,
  input logic           uv_a,
  input logic           clr_a,
  input logic           ot_a,
  input logic [NCH-1:0] oc_latch
);
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == '0); // R8
  AST_DEAD_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ((gate_hi & $past(gate_lo)) == '0) && ((gate_lo & $past(gate_hi)) == '0)); // R8
  AST_UV_SAFE: assert property (@(posedge clk) disable iff (rst)
    uv_a |=> (gate_hi == '0) && (gate_lo == '0) && !pump_en && !fault_n); // R2
  AST_OT_SAFE: assert property (@(posedge clk) disable iff (rst)
    ot_a |=> (gate_hi == '0) && (gate_lo == '0) && !fault_n); // R3
  AST_OT_PUMP_ON: assert property (@(posedge clk) disable iff (rst)
    (ot_a && !uv_a && !sleep_a) |=> pump_en); // R3
  AST_SLEEP_SAFE: assert property (@(posedge clk) disable iff (rst)
    sleep_a |=> (gate_hi == '0) && (gate_lo == '0) && !reg_en && !pump_en); // R7
  AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (rst)
    clr_a |=> (gate_hi == '0) && (gate_lo == '0)); // R6
  AST_LATCH_OFF: assert property (@(posedge clk) disable iff (rst)
    (|oc_latch) |=> (((gate_hi | gate_lo) & $past(oc_latch)) == '0) && !fault_n); // R5
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!sleep_a && !uv_a && !clr_a) |=> (($past(oc_latch) & ~oc_latch) == '0)); // R5
endmodule

bind hb3_guard hb3_guard_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .pump_en(pump_en), .reg_en(reg_en), .fault_n(fault_n),
  .sleep_a(sleep_a), .uv_a(uv_a), .clr_a(clr_a), .ot_a(ot_a),
  .oc_latch(oc_latch)
);

// File: tb/hb3_guard_bench.sv
module hb3_guard_bench;
  localparam int NCH = 3, OCP = 6, WAKE = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] lvl = '0, en = '0, oc = '0;
  logic sleep_n = 1'b1, clear_n = 1'b1, uv = 1'b0, ot = 1'b0;
  logic [NCH-1:0] gate_hi, gate_lo;
  logic pump_en, reg_en, fault_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb3_guard #(.NCH(NCH), .OCP_CYC(OCP), .WAKE_CYC(WAKE)) u_hb3_guard (
    .clk(clk), .rst(rst), .drv_level(lvl), .drv_en(en), .sleep_n(sleep_n),
    .clear_n(clear_n), .uv_flag(uv), .ot_flag(ot), .oc_flag(oc),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .pump_en(pump_en),
    .reg_en(reg_en), .fault_n(fault_n));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model: two-stage input pipeline, then registered outputs
  typedef struct packed {
    logic [NCH-1:0] lvl, en, oc;
    logic sl_n, cl_n, uv, ot;
  } in_t;
  in_t p1, p2;
  int  m_wake;
  int  m_cnt [NCH];
  logic [NCH-1:0] m_lat, m_hi, m_lo;
  logic m_pump, m_reg, m_fault;

  function automatic in_t safe_in();
    in_t s;
    s = '0;
    s.sl_n = 1'b1;
    s.cl_n = 1'b1;
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      p1 = safe_in(); p2 = safe_in(); m_wake = 0; m_lat = '0;
      m_hi = '0; m_lo = '0; m_pump = 1'b0; m_reg = 1'b0; m_fault = 1'b1;
      for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    end else begin
      bit sl, wipe, run;
      logic [NCH-1:0] lat_old, hi_old, lo_old;
      sl = !p2.sl_n;
      wipe = sl || p2.uv || !p2.cl_n;
      run = !wipe && !p2.ot && (m_wake == 0);
      lat_old = m_lat; hi_old = m_hi; lo_old = m_lo;
      m_pump = !sl && !p2.uv;
      m_reg = !sl;
      m_fault = !(p2.uv || p2.ot || (lat_old != 0));
      for (int i = 0; i < NCH; i++) begin
        bit ok;
        ok = run && !lat_old[i] && p2.en[i];
        m_hi[i] = ok && p2.lvl[i] && !lo_old[i];
        m_lo[i] = ok && !p2.lvl[i] && !hi_old[i];
        if (wipe) begin m_cnt[i] = 0; m_lat[i] = 1'b0; end
        else if (!p2.oc[i]) m_cnt[i] = 0;
        else if (!lat_old[i]) begin
          if (m_cnt[i] == OCP - 1) m_lat[i] = 1'b1;
          else m_cnt[i]++;
        end
      end
      if (sl) m_wake = WAKE;
      else if (m_wake != 0) m_wake--;
      p2 = p1;
      p1 = '{lvl: lvl, en: en, oc: oc, sl_n: sleep_n, cl_n: clear_n, uv: uv, ot: ot};
    end
  end

  always @(negedge clk) if (!rst && !done) begin
    chk("R1", "model gate_hi", int'(gate_hi), int'(m_hi));
    chk("R1", "model gate_lo", int'(gate_lo), int'(m_lo));
    chk("R2", "model pump_en", int'(pump_en), int'(m_pump));
    chk("R7", "model reg_en",  int'(reg_en),  int'(m_reg));
    chk("R5", "model fault_n", int'(fault_n), int'(m_fault));
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    tick(3);
    chk("R10", "reset gate_hi", int'(gate_hi), 0);
    chk("R10", "reset gate_lo", int'(gate_lo), 0);
    chk("R10", "reset pump/reg", int'({pump_en, reg_en}), 0);
    chk("R10", "reset fault_n", int'(fault_n), 1);
    rst = 1'b0;
    tick(1);
    chk("R10", "after reset fault_n", int'(fault_n), 1);
    en = 3'b111; lvl = 3'b101;
    tick(2);
    chk("R9", "gate_hi after 2 edges", int'(gate_hi), 0);
    tick(1);
    chk("R9", "gate_hi after 3 edges", int'(gate_hi), 5);
    chk("R1", "gate_lo table", int'(gate_lo), 2);
    lvl = 3'b010;
    tick(3);
    chk("R8", "dead cycle hi", int'(gate_hi), 0);
    chk("R8", "dead cycle lo", int'(gate_lo), 0);
    tick(1);
    chk("R8", "new side hi", int'(gate_hi), 2);
    chk("R8", "new side lo", int'(gate_lo), 5);
    en = 3'b011;
    tick(3);
    chk("R1", "disabled channel off", int'(gate_lo), 1);
    en = 3'b111;
    tick(4);
    oc = 3'b001;
    tick(OCP - 1);
    oc = 3'b000;
    tick(6);
    chk("R4", "short pulse keeps drive", int'(gate_lo), 5);
    chk("R4", "short pulse fault_n", int'(fault_n), 1);
    oc = 3'b001;
    tick(OCP);
    oc = 3'b000;
    tick(4);
    chk("R5", "latched channel off lo", int'(gate_lo), 4);
    chk("R5", "other channel on hi", int'(gate_hi), 2);
    chk("R5", "fault_n low", int'(fault_n), 0);
    tick(20);
    chk("R5", "latch holds", int'(gate_lo), 4);
    clear_n = 1'b0;
    lvl = 3'b111;
    tick(4);
    chk("R6", "clear gates off", int'(gate_hi | gate_lo), 0);
    chk("R6", "clear releases fault", int'(fault_n), 1);
    clear_n = 1'b1;
    tick(4);
    chk("R6", "after clear drive", int'(gate_hi), 7);
    oc = 3'b100;
    tick(OCP);
    oc = 3'b000;
    tick(4);
    chk("R5", "ch2 latched", int'(gate_hi), 3);
    uv = 1'b1;
    tick(4);
    chk("R2", "uv gates off", int'(gate_hi | gate_lo), 0);
    chk("R2", "uv pump off", int'(pump_en), 0);
    chk("R2", "uv fault low", int'(fault_n), 0);
    uv = 1'b0;
    tick(4);
    chk("R2", "uv recovery clears latch", int'(gate_hi), 7);
    chk("R2", "uv recovery pump", int'(pump_en), 1);
    chk("R2", "uv recovery fault", int'(fault_n), 1);
    ot = 1'b1;
    tick(4);
    chk("R3", "ot gates off", int'(gate_hi | gate_lo), 0);
    chk("R3", "ot pump on", int'(pump_en), 1);
    chk("R3", "ot fault low", int'(fault_n), 0);
    ot = 1'b0;
    tick(4);
    chk("R3", "ot recovery", int'(gate_hi), 7);
    chk("R3", "ot fault released", int'(fault_n), 1);
    sleep_n = 1'b0;
    tick(4);
    chk("R7", "sleep gates off", int'(gate_hi | gate_lo), 0);
    chk("R7", "sleep enables off", int'({pump_en, reg_en}), 0);
    sleep_n = 1'b1;
    tick(WAKE + 2);
    chk("R7", "wake delay still off", int'(gate_hi), 0);
    chk("R7", "wake reg on", int'(reg_en), 1);
    tick(1);
    chk("R7", "wake delay done", int'(gate_hi), 7);

    for (int c = 0; c < 6000; c++) begin
      if ($urandom % 8 == 0) lvl = NCH'($urandom);
      if ($urandom % 16 == 0) en = NCH'($urandom);
      for (int i = 0; i < NCH; i++)
        if (oc[i]) oc[i] = ($urandom % 4) != 0;
        else       oc[i] = ($urandom % 40) == 0;
      if (sleep_n) sleep_n = ($urandom % 500) != 0; else sleep_n = ($urandom % 30) == 0;
      if (!uv) uv = ($urandom % 400) == 0; else uv = ($urandom % 20) != 0;
      if (!ot) ot = ($urandom % 300) == 0; else ot = ($urandom % 20) != 0;
      if (clear_n) clear_n = ($urandom % 400) != 0; else clear_n = ($urandom % 5) == 0;
      tick(1);
    end
    done = 1'b1;
    summary();
  end
endmodule